// File: doc/BRIEF.md
# LIN Synch Byte Early-Edge Checker

This block watches the received LIN line while the 0x55 synch byte of a header goes by, and raises a header-error flag when a falling edge arrives too early. A header state machine pulses a start strobe once the break delimiter ends. The checker then waits for the first falling edge, which is the start bit, and times the four falling edges that follow. The line is sampled only on a 16x oversampling tick. All times are counted in those ticks. A nominal bit length, in ticks, is supplied as an input.

Each edge goes through two independent tests. The position test compares the edge's offset from the start-bit edge against its nominal offset. The spacing test compares the gap since the previous edge against two nominal bits. Both tests flag early edges only. Late edges are never flagged. Instead the block reports the total time from the first to the fifth falling edge, so that an outside whole-byte deviation check can catch slow lines. The error flag stays set until the next start strobe. A one-cycle done strobe marks the end of the byte.

Top module: `lin_sync_checker`

## Requirements
- R1: After reset `hdr_err`, `sync_done` and `sync_total` are all zero.
- R2: `sync_start` clears `hdr_err` in the following cycle and arms the checker. Falling edges seen while the checker is not armed produce no `sync_done` and no error.
- R3: Position test. For the k-th falling edge after the start-bit edge (k = 1..4), let the measured offset be P ticks and the nominal offset be E = 2·k·`bit_ticks`. The error is raised when (E − P)·128 > E·19.
- R4: Spacing test. For a gap of G ticks between consecutive falling edges, with nominal gap N = 2·`bit_ticks`, the error is raised when (N − G)·128 > N·22.
- R5: An edge that arrives at or after its nominal position, and a gap at or above its nominal value, never raise the error.
- R6: `sync_done` is high for exactly one cycle, right after the fifth falling edge has been processed. At that point `sync_total` equals the tick count from the first falling edge to the fifth.
- R7: Once set, `hdr_err` stays high until the next `sync_start`.
- R8: `rx_in` is observed only in cycles where `os_tick` is high. A low pulse on `rx_in` confined to cycles without a tick has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | 16x oversampling enable |
| rx_in | input | 1 | Synchronized receive line |
| sync_start | input | 1 | End-of-break-delimiter strobe; arms the checker |
| bit_ticks | input | NOM_W | Nominal bit length in ticks |
| hdr_err | output | 1 | Sticky early-edge header error |
| sync_done | output | 1 | One-cycle strobe after the fifth falling edge |
| sync_total | output | NOM_W+4 | Ticks from the first to the fifth falling edge |

## Verification
The checker module watches four rules on every cycle. `sync_done` never lasts two cycles. It only follows a cycle with a tick. `hdr_err` holds until a start strobe. A start strobe always clears it. Only the bench scenarios can show the threshold arithmetic: early gaps on either side of each limit, late edges that must stay silent, a second nominal bit length, a glitch between ticks, and edges that arrive while the checker is not armed.

// File: rtl/lin_sync_pkg.sv
package lin_sync_pkg;
  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_HUNT = 2'd1,
    SC_MEAS = 2'd2
  } sc_state_e;

  // falling edges in a 0x55 synch byte
  localparam int unsigned SYNC_EDGES = 5;
  // limits expressed in 1/128 of the nominal span
  localparam int unsigned LIM_SHIFT  = 7;
  localparam int unsigned POS_LIMIT  = 19;
  localparam int unsigned GAP_LIMIT  = 22;
endpackage

// File: rtl/lin_fall_det.sv
module lin_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx,
  output logic fall
);
  logic prev_q, prev_d;

  always_comb begin
    prev_d = prev_q;
    if (tick) prev_d = rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_d;
  end

  assign fall = tick & prev_q & ~rx;
endmodule

// File: rtl/lin_span_timer.sv
module lin_span_timer #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr,
  input  logic         mark,
  output logic [W-1:0] pos_now,
  output logic [W-1:0] gap
);
  logic [W-1:0] pos_q, pos_d, last_q, last_d;

  always_comb begin
    pos_now = (pos_q == {W{1'b1}}) ? pos_q : pos_q + 1'b1;
    gap     = pos_now - last_q;
    pos_d   = pos_q;
    last_d  = last_q;
    if (tick) begin
      if (clr) begin
        pos_d  = '0;
        last_d = '0;
      end else begin
        pos_d = pos_now;
        if (mark) last_d = pos_now;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      last_q <= '0;
    end else begin
      pos_q  <= pos_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/lin_early_cmp.sv
module lin_early_cmp #(
  parameter int unsigned W     = 12,
  parameter int unsigned LIMIT = 19,
  parameter int unsigned SH    = 7
) (
  input  logic [W-1:0] actual,
  input  logic [W-1:0] expected,
  output logic         too_early
);
  localparam int unsigned XW = W + SH;

  logic [W-1:0]  early;
  logic [XW-1:0] lhs, rhs;

  always_comb begin
    early     = (expected > actual) ? expected - actual : '0;
    lhs       = {early, {SH{1'b0}}};
    rhs       = XW'(expected) * XW'(LIMIT);
    too_early = lhs > rhs;
  end
endmodule

// File: rtl/lin_sync_checker.sv
module lin_sync_checker
  import lin_sync_pkg::*;
#(
  parameter int unsigned NOM_W = 8,
  localparam int unsigned POS_W = NOM_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             os_tick,
  input  logic             rx_in,
  input  logic             sync_start,
  input  logic [NOM_W-1:0] bit_ticks,
  output logic             hdr_err,
  output logic             sync_done,
  output logic [POS_W-1:0] sync_total
);
  localparam int unsigned CW = $clog2(SYNC_EDGES);
  localparam logic [CW-1:0] LAST_IDX = CW'(SYNC_EDGES - 2);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  sc_state_e        st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [POS_W-1:0] exp_q, exp_d, tot_q, tot_d;
  logic             err_q, err_d, done_q, done_d;
  logic             fall, clr, mark, pos_bad, gap_bad;
  logic [POS_W-1:0] pos_now, gap, two_nom;

  assign two_nom = {{(POS_W-NOM_W-1){1'b0}}, bit_ticks, 1'b0};

  lin_fall_det u_fall (
    .clk (clk), .rst_n (rst_q), .tick (os_tick), .rx (rx_in), .fall (fall)
  );

  lin_span_timer #(.W(POS_W)) u_tmr (
    .clk (clk), .rst_n (rst_q), .tick (os_tick), .clr (clr), .mark (mark),
    .pos_now (pos_now), .gap (gap)
  );

  lin_early_cmp #(.W(POS_W), .LIMIT(POS_LIMIT), .SH(LIM_SHIFT)) u_pos (
    .actual (pos_now), .expected (exp_q), .too_early (pos_bad)
  );

  lin_early_cmp #(.W(POS_W), .LIMIT(GAP_LIMIT), .SH(LIM_SHIFT)) u_gap (
    .actual (gap), .expected (two_nom), .too_early (gap_bad)
  );

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    exp_d  = exp_q;
    tot_d  = tot_q;
    err_d  = err_q;
    done_d = 1'b0;
    clr    = 1'b0;
    mark   = 1'b0;
    if (sync_start) begin
      st_d  = SC_HUNT;
      err_d = 1'b0;
    end else begin
      case (st_q)
        SC_HUNT: if (fall) begin
          clr   = 1'b1;
          st_d  = SC_MEAS;
          cnt_d = '0;
          exp_d = two_nom;
        end
        SC_MEAS: if (fall) begin
          mark  = 1'b1;
          err_d = err_q | pos_bad | gap_bad;
          exp_d = exp_q + two_nom;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_IDX) begin
            done_d = 1'b1;
            tot_d  = pos_now;
            st_d   = SC_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q   <= SC_IDLE;
      cnt_q  <= '0;
      exp_q  <= '0;
      tot_q  <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      exp_q  <= exp_d;
      tot_q  <= tot_d;
      err_q  <= err_d;
      done_q <= done_d;
    end
  end

  assign hdr_err    = err_q;
  assign sync_done  = done_q;
  assign sync_total = tot_q;
endmodule

// File: rtl/lin_sync_checker_chk.sv
module lin_sync_checker_chk (
  input logic clk,
  input logic rst_n,
  input logic os_tick,
  input logic sync_start,
  input logic hdr_err,
  input logic sync_done
);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |=> !sync_done);

  // R8
  done_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |-> $past(os_tick));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_err && !sync_start) |=> hdr_err);

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_start |=> !hdr_err);
endmodule

bind lin_sync_checker lin_sync_checker_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .os_tick    (os_tick),
  .sync_start (sync_start),
  .hdr_err    (hdr_err),
  .sync_done  (sync_done)
);

// File: tb/tb_lin_sync_checker.sv
module tb_lin_sync_checker;
  localparam int NOM_W = 8;
  localparam int POS_W = NOM_W + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic rx_in = 1'b1;
  logic sync_start = 1'b0;
  logic [NOM_W-1:0] bit_ticks = 8'd16;
  logic hdr_err, sync_done;
  logic [POS_W-1:0] sync_total;

  int checks = 0;
  int errors = 0;
  int n_done = 0;
  bit finished = 0;

  typedef struct { bit err; int total; string tag; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  lin_sync_checker #(.NOM_W(NOM_W)) dut (
    .clk (clk), .rst_n (rst_n), .os_tick (os_tick), .rx_in (rx_in),
    .sync_start (sync_start), .bit_ticks (bit_ticks),
    .hdr_err (hdr_err), .sync_done (sync_done), .sync_total (sync_total)
  );

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick_once(bit glitch);
    @(negedge clk) os_tick = 1'b1;
    @(negedge clk) os_tick = 1'b0;
    if (glitch) begin
      rx_in = 1'b0;
      @(negedge clk) rx_in = 1'b1;
    end
  endtask

  // driver: computes expectation from R3/R4/R6, then drives the byte
  task automatic frame(string tag, int nom, int g1, int g2, int g3, int g4,
                       bit do_start, bit glitch);
    int g[4];
    int pos, ex, early, gap;
    exp_t e;
    g = '{g1, g2, g3, g4};
    e.err = 0; e.total = 0; e.tag = tag; pos = 0;
    for (int k = 1; k <= 4; k++) begin
      pos += g[k-1];
      ex = 2 * k * nom;
      early = (ex > pos) ? ex - pos : 0;
      if (early * 128 > ex * 19) e.err = 1;           // R3
      early = (2 * nom > g[k-1]) ? 2 * nom - g[k-1] : 0;
      if (early * 128 > 2 * nom * 22) e.err = 1;      // R4
    end
    e.total = pos;
    if (do_start) exp_q.push_back(e);
    bit_ticks = NOM_W'(nom);
    if (do_start) begin
      @(negedge clk) sync_start = 1'b1;
      @(negedge clk) sync_start = 1'b0;
    end
    rx_in = 1'b1;
    repeat (3) tick_once(1'b0);
    for (int i = 0; i < 5; i++) begin
      gap = (i < 4) ? g[i] : 4;
      for (int j = 0; j < gap; j++) begin
        rx_in = (j < gap / 2) ? 1'b0 : 1'b1;
        tick_once(glitch && i == 0 && j == gap - 2);
      end
    end
    repeat (3) tick_once(1'b0);
  endtask

  // monitor: pops the scoreboard on each done strobe
  initial begin
    bit prev_done = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (sync_done) begin
        n_done++;
        check("R6 done width", prev_done, 0);
        if (exp_q.size() == 0) begin
          check("R2 unexpected done", 1, 0);
        end else begin
          e = exp_q.pop_front();
          check({"R3/R4 err ", e.tag}, hdr_err, e.err);
          check({"R6 total ", e.tag}, int'(sync_total), e.total);
        end
      end
      prev_done = sync_done;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int d0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 err", hdr_err, 0);
    check("R1 done", sync_done, 0);
    check("R1 total", int'(sync_total), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    frame("nominal", 16, 32, 32, 32, 32, 1, 0);
    frame("pos_early5_R3", 16, 27, 32, 32, 32, 1, 0);
    // R7 sticky while idle
    repeat (5) tick_once(1'b0);
    check("R7 sticky", hdr_err, 1);
    @(negedge clk) sync_start = 1'b1;
    @(negedge clk) sync_start = 1'b0;
    check("R2 start clears", hdr_err, 0);

    frame("early4_ok", 16, 28, 32, 32, 32, 1, 0);
    frame("gap_early6_R4", 16, 32, 32, 32, 26, 1, 0);
    frame("gap_early5_ok_R4", 16, 32, 32, 32, 27, 1, 0);
    frame("late_R5", 16, 40, 40, 40, 40, 1, 0);
    frame("late_big_R5", 16, 48, 33, 60, 35, 1, 0);
    frame("steady28", 16, 28, 28, 28, 28, 1, 0);
    frame("nom12", 12, 24, 24, 24, 24, 1, 0);
    frame("nom12_early", 12, 24, 24, 19, 24, 1, 0);
    frame("glitch_R8", 16, 32, 32, 32, 32, 1, 1);

    // R2: edges without arming
    d0 = n_done;
    frame("unarmed", 16, 20, 20, 20, 20, 0, 0);
    check("R2 no done unarmed", n_done, d0);
    check("R2 no err unarmed", hdr_err, 0);

    repeat (10) @(negedge clk);
    check("R6 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule